// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits on a handheld CPU's 16-bit address bus and 8-bit data bus, in front of a cartridge ROM of up to 2 MB and a battery-backed RAM of up to 32 KB. The ROM address space cannot be written, so CPU writes that land in it are taken as control-register writes. Four write pages hold four settings: a RAM gate, a 5-bit low ROM bank, a 2-bit high field and a banking-mode bit. The block combines these settings with the bus address. From them it drives the full ROM address, the full RAM address, a RAM chip enable and a RAM write strobe. It also steers read data back onto the CPU bus.

The window at 0x0000-0x3FFF always shows ROM bank 0. The window at 0x4000-0x7FFF shows the selected ROM bank. External RAM sits at 0xA000-0xBFFF.

The mode bit decides who owns the 2-bit field:
- In ROM-heavy mode the field supplies the top two ROM bank bits, and RAM stays in bank 0.
- In RAM-heavy mode the field picks one of four 8 KB RAM banks, and the upper ROM window is limited to banks 0x01-0x1F.

Everything is combinational from the bus address, except the four setting registers. Register writes take effect from the clock edge on which `bus_wr` is sampled high.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset, the ROM window at 0x4000-0x7FFF maps ROM bank 1, the mode is ROM-heavy, the high field is 0 and external RAM is disabled.
- R2: A bus address in 0x0000-0x3FFF always gives `rom_addr` = {7'b0, bus_addr[13:0]}, whatever the register contents.
- R3: A write to 0x2000-0x3FFF loads bits 4:0 of the data into the low bank, and bits 7:5 are ignored. An access in 0x4000-0x7FFF then gives `rom_addr[18:14]` = the low bank and `rom_addr[13:0]` = bus_addr[13:0].
- R4: A value of 0 written to the low bank is stored as 1. Upper-window banks 0x00, 0x20, 0x40 and 0x60 are therefore never produced.
- R5: A write to 0x4000-0x5FFF loads data bits 1:0 into the high field. In ROM-heavy mode, an access to the upper window gives `rom_addr[20:19]` = the high field, and `ram_addr[14:13]` = 0.
- R6: A write to 0x6000-0x7FFF sets the mode from data bit 0, where 0 is ROM-heavy and 1 is RAM-heavy. In RAM-heavy mode, `ram_addr[14:13]` = the high field and `rom_addr[20:19]` = 0, so the four RAM banks hold separate data.
- R7: A write to 0x0000-0x1FFF enables RAM when data bits 3:0 equal 0xA. Any other value disables RAM.
- R8: With RAM enabled, an access in 0xA000-0xBFFF asserts `ram_ce`, gives `ram_addr[12:0]` = bus_addr[12:0], and drives `ram_we` from `bus_wr`. A read there returns `ram_rdata` on `bus_rdata`.
- R9: With RAM disabled, an access in 0xA000-0xBFFF keeps `ram_ce` and `ram_we` low and returns 0xFF. A write there leaves the RAM contents unchanged.
- R10: A read in 0x0000-0x7FFF returns `rom_rdata`. A read at any address outside both the ROM windows and the RAM window returns 0xFF.
- R11: A write at 0x8000 or above changes none of the four settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_wr | input | 1 | CPU write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data steered to the CPU |
| rom_addr | output | 21 | Cartridge ROM byte address |
| rom_rdata | input | 8 | Cartridge ROM data |
| ram_addr | output | 15 | Cartridge RAM byte address |
| ram_ce | output | 1 | RAM chip enable |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |

## Verification
The bench writes 0 to the low bank, both directly and as 0x20 with the top bits set. A design without the remap would then expose bank 0 in the upper window, or bank 0x60 after the high field is set to 3.

The bench also switches modes with data left in two RAM banks. A design that mixed up ownership of the 2-bit field would read the wrong bank, or would leak the high field onto ROM address lines 20:19 in RAM-heavy mode.

RAM gating is tested with the non-enabling value 0x0B, with a write attempted while RAM is disabled, and with 0x5A and 0xFA. A design that decoded the whole byte, or that let a disabled write through, would read back the wrong value.

Writes at 0x8000 and 0xE000 must leave every setting as it was.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int CPU_AW = 16;
  localparam int CPU_DW = 8;
  localparam logic [3:0] RAM_KEY = 4'hA;
  localparam logic [CPU_DW-1:0] OPEN_BUS = '1;

  typedef enum logic {
    MODE_ROM_HEAVY = 1'b0,
    MODE_RAM_HEAVY = 1'b1
  } bank_mode_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RAM_GATE,
    SEL_LO_BANK,
    SEL_HI_FIELD,
    SEL_MODE
  } reg_sel_e;

  // 8 KB write page (bus_addr[15:13]) to register select
  function automatic reg_sel_e page_to_sel(input logic [2:0] page);
    case (page)
      3'd0:    return SEL_RAM_GATE;
      3'd1:    return SEL_LO_BANK;
      3'd2:    return SEL_HI_FIELD;
      3'd3:    return SEL_MODE;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/cbc_wr_decode.sv
module cbc_wr_decode
  import cbc_pkg::*;
(
  input  logic                wr_en,
  input  logic [CPU_AW-1:0]   addr,
  output reg_sel_e            sel
);
  always_comb begin
    sel = SEL_NONE;
    if (wr_en) sel = page_to_sel(addr[CPU_AW-1 -: 3]);
  end
endmodule

// File: rtl/cbc_bank_regs.sv
module cbc_bank_regs
  import cbc_pkg::*;
#(
  parameter int LO_W = 5,
  parameter int HI_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  reg_sel_e          sel,
  input  logic [CPU_DW-1:0] wdata,
  output logic              ram_on,
  output logic [LO_W-1:0]   lo_bank,
  output logic [HI_W-1:0]   hi_field,
  output bank_mode_e        mode
);
  localparam logic [LO_W-1:0] LO_RESET = LO_W'(1);

  logic [LO_W-1:0] lo_next;
  // bank 0 cannot be chosen for the switchable window
  assign lo_next = (wdata[LO_W-1:0] == '0) ? LO_RESET : wdata[LO_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_on   <= 1'b0;
      lo_bank  <= LO_RESET;
      hi_field <= '0;
      mode     <= MODE_ROM_HEAVY;
    end else begin
      case (sel)
        SEL_RAM_GATE: ram_on   <= (wdata[3:0] == RAM_KEY);
        SEL_LO_BANK:  lo_bank  <= lo_next;
        SEL_HI_FIELD: hi_field <= wdata[HI_W-1:0];
        SEL_MODE:     mode     <= bank_mode_e'(wdata[0]);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cbc_addr_map.sv
module cbc_addr_map
  import cbc_pkg::*;
#(
  parameter int ROM_WIN_W = 14,
  parameter int RAM_WIN_W = 13,
  parameter int LO_W = 5,
  parameter int HI_W = 2,
  localparam int ROM_AW = ROM_WIN_W + LO_W + HI_W,
  localparam int RAM_AW = RAM_WIN_W + HI_W
) (
  input  logic [CPU_AW-1:0] addr,
  input  logic [LO_W-1:0]   lo_bank,
  input  logic [HI_W-1:0]   hi_field,
  input  bank_mode_e        mode,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              in_rom,
  output logic              in_ram
);
  localparam logic [2:0] RAM_PAGE = 3'b101;

  logic            upper;
  logic [LO_W-1:0] rom_lo;
  logic [HI_W-1:0] rom_hi;
  logic [HI_W-1:0] ram_hi;

  always_comb begin
    in_rom = ~addr[CPU_AW-1];
    in_ram = (addr[CPU_AW-1 -: 3] == RAM_PAGE);
    upper  = addr[ROM_WIN_W];
    rom_lo = upper ? lo_bank : '0;
    rom_hi = (upper && mode == MODE_ROM_HEAVY) ? hi_field : '0;
    ram_hi = (mode == MODE_RAM_HEAVY) ? hi_field : '0;
    rom_addr = {rom_hi, rom_lo, addr[ROM_WIN_W-1:0]};
    ram_addr = {ram_hi, addr[RAM_WIN_W-1:0]};
  end
endmodule

// File: rtl/cbc_rdata_mux.sv
module cbc_rdata_mux
  import cbc_pkg::*;
(
  input  logic              in_rom,
  input  logic              in_ram,
  input  logic              ram_on,
  input  logic [CPU_DW-1:0] rom_rdata,
  input  logic [CPU_DW-1:0] ram_rdata,
  output logic [CPU_DW-1:0] bus_rdata
);
  always_comb begin
    if (in_rom)                bus_rdata = rom_rdata;
    else if (in_ram && ram_on) bus_rdata = ram_rdata;
    else                       bus_rdata = OPEN_BUS;
  end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int ROM_WIN_W = 14,
  parameter int RAM_WIN_W = 13,
  parameter int LO_W = 5,
  parameter int HI_W = 2,
  localparam int ROM_AW = ROM_WIN_W + LO_W + HI_W,
  localparam int RAM_AW = RAM_WIN_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] bus_addr,
  input  logic [CPU_DW-1:0] bus_wdata,
  input  logic              bus_wr,
  output logic [CPU_DW-1:0] bus_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [CPU_DW-1:0] rom_rdata,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_ce,
  output logic              ram_we,
  output logic [CPU_DW-1:0] ram_wdata,
  input  logic [CPU_DW-1:0] ram_rdata
);
  reg_sel_e        sel;
  logic            ram_on;
  logic [LO_W-1:0] lo_bank;
  logic [HI_W-1:0] hi_field;
  bank_mode_e      mode;
  logic            in_rom;
  logic            in_ram;

  cbc_wr_decode u_dec (
    .wr_en (bus_wr),
    .addr  (bus_addr),
    .sel   (sel)
  );

  cbc_bank_regs #(.LO_W(LO_W), .HI_W(HI_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .wdata    (bus_wdata),
    .ram_on   (ram_on),
    .lo_bank  (lo_bank),
    .hi_field (hi_field),
    .mode     (mode)
  );

  cbc_addr_map #(
    .ROM_WIN_W(ROM_WIN_W), .RAM_WIN_W(RAM_WIN_W), .LO_W(LO_W), .HI_W(HI_W)
  ) u_map (
    .addr     (bus_addr),
    .lo_bank  (lo_bank),
    .hi_field (hi_field),
    .mode     (mode),
    .rom_addr (rom_addr),
    .ram_addr (ram_addr),
    .in_rom   (in_rom),
    .in_ram   (in_ram)
  );

  cbc_rdata_mux u_rmux (
    .in_rom    (in_rom),
    .in_ram    (in_ram),
    .ram_on    (ram_on),
    .rom_rdata (rom_rdata),
    .ram_rdata (ram_rdata),
    .bus_rdata (bus_rdata)
  );

  assign ram_ce    = in_ram & ram_on;
  assign ram_we    = ram_ce & bus_wr;
  assign ram_wdata = bus_wdata;
endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk #(
  parameter int ROM_AW = 21,
  parameter int RAM_AW = 15,
  parameter int ROM_WIN_W = 14,
  parameter int RAM_WIN_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_wr,
  input logic [7:0]        bus_rdata,
  input logic [ROM_AW-1:0] rom_addr,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              ram_ce,
  input logic              ram_we
);
  localparam int LO_W = ROM_AW - ROM_WIN_W - 2;

  p_lower_bank0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[15:14] == 2'b00) |-> (rom_addr[ROM_AW-1:ROM_WIN_W] == '0));

  p_lo_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[15:13] == 3'b001 && bus_wdata[LO_W-1:0] != '0)
    |=> (bus_addr[15:14] != 2'b01 ||
         rom_addr[ROM_WIN_W +: LO_W] == $past(bus_wdata[LO_W-1:0])));

  p_no_bank_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[15:14] == 2'b01) |-> (rom_addr[ROM_WIN_W +: LO_W] != '0));

  p_field_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_addr[RAM_AW-1:RAM_WIN_W] != '0) |-> (rom_addr[ROM_AW-1 -: 2] == '0));

  p_gate_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[15:13] == 3'b000 && bus_wdata[3:0] != 4'hA) |=> !ram_ce);

  p_off_reads_ff_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[15:13] == 3'b101 && !ram_ce) |-> (bus_rdata == 8'hFF && !ram_we));

  p_open_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[15] && bus_addr[15:13] != 3'b101) |-> (bus_rdata == 8'hFF && !ram_ce));
endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(
  .ROM_AW(ROM_AW), .RAM_AW(RAM_AW), .ROM_WIN_W(ROM_WIN_W), .RAM_WIN_W(RAM_WIN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rdata(bus_rdata), .rom_addr(rom_addr),
  .ram_addr(ram_addr), .ram_ce(ram_ce), .ram_we(ram_we)
);

// File: tb/cart_bank_ctrl_bench.sv
`timescale 1ns/1ps
module cart_bank_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_rdata;
  logic [20:0] rom_addr;
  logic [7:0]  rom_rdata;
  logic [14:0] ram_addr;
  logic        ram_ce, ram_we;
  logic [7:0]  ram_wdata, ram_rdata;
  logic [7:0]  ram_mem [0:63];

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cart_bank_ctrl u_cart_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .rom_addr(rom_addr),
    .rom_rdata(rom_rdata), .ram_addr(ram_addr), .ram_ce(ram_ce),
    .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  // behavioural ROM: byte derived from its address
  function automatic logic [7:0] rom_byte(input logic [20:0] ra);
    return ra[7:0] ^ {1'b0, ra[20:14]};
  endfunction
  assign rom_rdata = rom_byte(rom_addr);

  // behavioural RAM: bank bits plus low offset nibble
  assign ram_rdata = ram_mem[{ram_addr[14:13], ram_addr[3:0]}];
  always @(posedge clk) if (ram_we) ram_mem[{ram_addr[14:13], ram_addr[3:0]}] <= ram_wdata;

  typedef struct {
    logic [20:0] rom_a;
    bit          chk_rom;
    logic [14:0] ram_a;
    bit          chk_ram;
    logic        ce;
    logic [7:0]  rd;
    string       tag;
  } item_t;

  item_t sb_q[$];

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic push_read(input logic [15:0] a, input item_t it);
    @(posedge clk); #1;
    bus_addr = a; bus_wr = 1'b0;
    sb_q.push_back(it);
  endtask

  task automatic rd_rom(input logic [15:0] a, input logic [6:0] bank, input string tag);
    item_t it;
    it.rom_a = {bank, a[13:0]}; it.chk_rom = 1'b1;
    it.ram_a = '0; it.chk_ram = 1'b0; it.ce = 1'b0;
    it.rd = rom_byte(it.rom_a); it.tag = tag;
    push_read(a, it);
  endtask

  task automatic rd_ram(input logic [15:0] a, input logic [1:0] bank, input logic ce,
                        input logic [7:0] d, input string tag);
    item_t it;
    it.rom_a = '0; it.chk_rom = 1'b0;
    it.ram_a = {bank, a[12:0]}; it.chk_ram = ce; it.ce = ce;
    it.rd = d; it.tag = tag;
    push_read(a, it);
  endtask

  task automatic rd_open(input logic [15:0] a, input string tag);
    item_t it;
    it.rom_a = '0; it.chk_rom = 1'b0; it.ram_a = '0; it.chk_ram = 1'b0;
    it.ce = 1'b0; it.rd = 8'hFF; it.tag = tag;
    push_read(a, it);
  endtask

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_vec++;
      if ((it.chk_rom && rom_addr !== it.rom_a) || (it.chk_ram && ram_addr !== it.ram_a) ||
          ram_ce !== it.ce || bus_rdata !== it.rd) begin
        n_bad++;
        $display("FAIL %s: rom_addr=%h ram_addr=%h ce=%b rdata=%h exp rom_addr=%h ram_addr=%h ce=%b rdata=%h",
                 it.tag, rom_addr, ram_addr, ram_ce, bus_rdata,
                 it.rom_a, it.ram_a, it.ce, it.rd);
      end
    end
  end

  task automatic do_reset;
    @(posedge clk); #1; rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1; rst_n = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) ram_mem[i] = 8'h00;
    do_reset();
    rd_rom(16'h4000, 7'h01, "R1 upper bank after reset");
    rd_ram(16'hA000, 2'd0, 1'b0, 8'hFF, "R1 RAM off after reset");
    rd_rom(16'h1234, 7'h00, "R2 lower window");
    bus_write(16'h2000, 8'hE5);
    rd_rom(16'h5ABC, 7'h05, "R3 low bank, top bits ignored");
    rd_rom(16'h3FFF, 7'h00, "R2 lower window after bank change");
    bus_write(16'h3FFF, 8'h00);
    rd_rom(16'h4001, 7'h01, "R4 zero becomes one");
    bus_write(16'h2100, 8'h20);
    rd_rom(16'h4002, 7'h01, "R4 0x20 low bits zero");
    bus_write(16'h4000, 8'h03);
    rd_rom(16'h7FFF, 7'h61, "R5 high field drives rom top bits");
    bus_write(16'h2000, 8'h00);
    rd_rom(16'h6000, 7'h61, "R4 bank 0x60 not selectable");
    bus_write(16'h2000, 8'h1F);
    rd_rom(16'h4123, 7'h7F, "R3 R5 bank 0x7F");
    bus_write(16'h0000, 8'h0A);
    rd_ram(16'hA003, 2'd0, 1'b1, 8'h00, "R5 R8 RAM bank 0 in ROM-heavy");
    bus_write(16'hA003, 8'h3C);
    rd_ram(16'hA003, 2'd0, 1'b1, 8'h3C, "R8 RAM write readback");
    bus_write(16'h6000, 8'h01);
    rd_rom(16'h4000, 7'h1F, "R6 RAM-heavy clears rom top bits");
    rd_ram(16'hA003, 2'd3, 1'b1, 8'h00, "R6 RAM bank 3 empty");
    bus_write(16'hA003, 8'h77);
    bus_write(16'h5000, 8'h00);
    rd_ram(16'hA003, 2'd0, 1'b1, 8'h3C, "R6 bank 0 kept separate");
    bus_write(16'h5000, 8'h03);
    rd_ram(16'hA003, 2'd3, 1'b1, 8'h77, "R6 bank 3 data");
    bus_write(16'h0000, 8'h0B);
    rd_ram(16'hA003, 2'd3, 1'b0, 8'hFF, "R7 R9 0x0B disables");
    bus_write(16'hA003, 8'h99);
    bus_write(16'h1FFF, 8'h5A);
    rd_ram(16'hA003, 2'd3, 1'b1, 8'h77, "R9 R7 disabled write ignored, 0x5A enables");
    bus_write(16'h1000, 8'hFA);
    rd_ram(16'hA004, 2'd3, 1'b1, 8'h00, "R7 0xFA enables");
    rd_open(16'h8000, "R10 video page open bus");
    rd_open(16'hC000, "R10 work RAM page open bus");
    rd_rom(16'h0100, 7'h00, "R10 ROM data returned");
    bus_write(16'h8000, 8'h00);
    bus_write(16'hE000, 8'h00);
    bus_write(16'hC000, 8'h01);
    rd_rom(16'h4000, 7'h1F, "R11 high writes leave bank and mode");
    rd_ram(16'hA003, 2'd3, 1'b1, 8'h77, "R11 high writes leave RAM gate and field");
    bus_write(16'h7FFF, 8'h00);
    rd_rom(16'h4000, 7'h7F, "R6 back to ROM-heavy");
    rd_ram(16'hA003, 2'd0, 1'b1, 8'h3C, "R5 ROM-heavy RAM bank 0");
    do_reset();
    rd_rom(16'h4000, 7'h01, "R1 bank after second reset");
    rd_ram(16'hA003, 2'd0, 1'b0, 8'hFF, "R1 RAM off after second reset");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule